// File: doc/BRIEF.md
# Twin-Quad Configurable Logic Cell

This block models one programmable logic cell of a fabric. It holds eight 4-input lookup tables. Each table stores 16 truth-table bits. The eight tables form two groups of four, and each group drives four storage elements. Every group has its own clock enable, local set/reset and storage options. A parallel configuration port loads the truth tables and a mode word one word per clock. This lets a host build any mix of logic, arithmetic and small memory without global routing.

Four operating modes are available. Logic mode presents the raw lookup results. Two arithmetic modes run a fast carry chain through the tables, either as two separate 4-bit adders or as one chained 8-bit adder. Memory mode reuses the 128 truth-table bits as a 32-word by 4-bit store. The store can act as a single-port RAM, a dual-port RAM with a separate asynchronous read address, or a ROM. A ninth flip-flop can capture either carry-out for pipelining, or a direct input.

Top module: `tq_cell`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, q_o, r9_o, comb_o and cout_o are all zero. All tables and config words are cleared by the reset.
- R2: A cfg_we_i write takes effect from the next clock. It goes to table k when cfg_addr_i = k (0 to 7), to the mode word at address 8, and to the ninth-FF select (bits 1:0) at address 9. Other addresses change nothing.
- R3: Mode word bits 1:0 = 0 selects logic mode. Here comb_o[k] is bit n of table k, where n = lut_in_i[4k+3:4k].
- R4: Mode 1 is the 4-bit arithmetic mode. With L the table output, c_j the carry into bit j and a the LUT input bit lut_in_i[4k], each bit gives sum = L xor c_j and c_(j+1) = L ? c_j : a. Each quad takes its own carry from cin_i[q] and drives cout_o[q].
- R5: Mode 2 is the 8-bit arithmetic mode. It feeds the carry-out of quad 0 into quad 1, and cin_i[1] is ignored. In modes 0 and 3, cout_o is zero.
- R6: Mode 3 is memory mode. Word w, bit b is table (4*w[4]+b), entry w[3:0]. A write with mem_we_i lands on the rising clock edge. Reads are asynchronous on comb_o[3:0], and comb_o[7:4] reads zero. Mode bits 3:2 pick the kind: 0 is single-port (the read address is mem_waddr_i), 1 is dual-port (the read address is mem_raddr_i), and 2 or 3 is ROM.
- R7: mem_we_i has no effect in ROM kind, outside memory mode, or in a cycle with cfg_we_i high.
- R8: Each group has a source field (mode bits 5:4 for group 0, 7:6 for group 1). It picks the storage data: 0 is the comb_o bit, 1 is d_i (inverted when bit 8 or 9 is set), 2 is constant 1 and 3 is constant 0.
- R9: The local set/reset sr_i[g] is synchronous and wins over ce_i[g]. It loads the group's value from mode bit 14 or 15. When neither is high, the element holds its value.
- R10: Mode bit 10 or 11 makes the group's flip-flops act on the falling clock edge.
- R11: Mode bit 12 or 13 turns the group into latches. They are transparent while the active clock phase lasts (high for rising polarity, low for falling) and hold when it ends.
- R12: The ninth flip-flop r9_o loads on the rising edge when ce9_i is high. Its source, picked by select 0 to 3, is cout_o[0], cout_o[1], d9_i or the inverse of d9_i. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Cell clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration word address |
| cfg_wdata_i | input | 16 | Configuration write data |
| lut_in_i | input | 32 | Four select inputs per table, table k at bits 4k+3:4k |
| cin_i | input | 2 | Carry into each quad |
| d_i | input | 8 | Direct data inputs of the storage elements |
| ce_i | input | 2 | Clock enable per group |
| sr_i | input | 2 | Synchronous local set/reset per group |
| d9_i | input | 1 | Direct input of the ninth flip-flop |
| ce9_i | input | 1 | Clock enable of the ninth flip-flop |
| mem_we_i | input | 1 | Memory write enable |
| mem_waddr_i | input | 5 | Memory write (and single-port read) address |
| mem_raddr_i | input | 5 | Dual-port read address |
| mem_wdata_i | input | 4 | Memory write data |
| comb_o | output | 8 | Lookup, sum or memory read result |
| cout_o | output | 2 | Carry-out of each quad |
| q_o | output | 8 | Storage element outputs |
| r9_o | output | 1 | Ninth flip-flop output |

## Verification
A corrupted truth-table bit shows up on comb_o in the same cycle that the select inputs address it. A broken carry link shows up as wrong sum bits and a wrong cout_o on the first propagate pattern. A storage element with a wrong enable, polarity or set/reset value shows a wrong q_o at the sample after its active edge or latch phase. The bench compares comb_o, cout_o, q_o and r9_o against a behavioural model on every clock. Any divergence is therefore reported within one cycle of the edge that caused it.

// File: rtl/tq_cell_pkg.sv
package tq_cell_pkg;
  localparam int unsigned NUM_LUT  = 8;
  localparam int unsigned QUAD_W   = 4;
  localparam int unsigned NUM_QUAD = NUM_LUT / QUAD_W;
  localparam int unsigned LUT_K    = 4;
  localparam int unsigned LUT_BITS = 1 << LUT_K;
  localparam int unsigned TAB_W    = NUM_LUT * LUT_BITS;
  localparam int unsigned CFG_W    = 16;
  localparam int unsigned CFG_AW   = 4;
  localparam int unsigned MEM_DW   = QUAD_W;
  localparam int unsigned MEM_AW   = $clog2(TAB_W / MEM_DW);
  localparam int unsigned QB       = $clog2(QUAD_W);
  localparam int unsigned SEL_W    = 2;

  localparam logic [CFG_AW-1:0] ADDR_MODE = CFG_AW'(NUM_LUT);
  localparam logic [CFG_AW-1:0] ADDR_AUX  = CFG_AW'(NUM_LUT + 1);

  typedef enum logic [1:0] {OP_LOGIC = 2'd0, OP_ADD4 = 2'd1, OP_ADD8 = 2'd2, OP_MEM = 2'd3} op_e;
  typedef enum logic [1:0] {MEM_SP = 2'd0, MEM_DP = 2'd1, MEM_ROM = 2'd2, MEM_ROM_ALT = 2'd3} mem_e;
  typedef enum logic [1:0] {SRC_LUT = 2'd0, SRC_PIN = 2'd1, SRC_ONE = 2'd2, SRC_ZERO = 2'd3} src_e;

  typedef struct packed {
    src_e src;
    logic inv;
    logic fall;
    logic latch;
    logic srval;
  } grp_cfg_t;

  function automatic grp_cfg_t grp_cfg(logic [CFG_W-1:0] w, int g);
    grp_cfg_t c;
    c.src   = src_e'(w[4 + 2*g +: 2]);
    c.inv   = w[8 + g];
    c.fall  = w[10 + g];
    c.latch = w[12 + g];
    c.srval = w[14 + g];
    return c;
  endfunction

  // word w, bit b lives in table 4*w[msb]+b at entry w[3:0]
  function automatic logic [MEM_DW-1:0] mem_word(logic [TAB_W-1:0] tab, logic [MEM_AW-1:0] a);
    logic [MEM_DW-1:0] r;
    for (int b = 0; b < MEM_DW; b++) r[b] = tab[{a[MEM_AW-1], b[QB-1:0], a[LUT_K-1:0]}];
    return r;
  endfunction
endpackage

// File: rtl/tq_cfg_store.sv
module tq_cfg_store
  import tq_cell_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              mem_we_i,
  input  logic [MEM_AW-1:0] mem_waddr_i,
  input  logic [MEM_DW-1:0] mem_wdata_i,
  output logic [TAB_W-1:0]  tab_o,
  output logic [CFG_W-1:0]  mode_o,
  output logic [SEL_W-1:0]  aux_o
);
  logic [TAB_W-1:0] tab_q;
  logic [CFG_W-1:0] mode_q;
  logic [SEL_W-1:0] aux_q;
  logic             mem_wr;
  logic             is_mem;
  logic             is_rom;

  assign is_mem = (op_e'(mode_q[1:0]) == OP_MEM);
  assign is_rom = mode_q[3];
  assign mem_wr = mem_we_i && !cfg_we_i && is_mem && !is_rom;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tab_q  <= '0;
      mode_q <= '0;
      aux_q  <= '0;
    end else if (cfg_we_i) begin
      if (int'(cfg_addr_i) < NUM_LUT) tab_q[int'(cfg_addr_i)*LUT_BITS +: LUT_BITS] <= cfg_wdata_i;
      else if (cfg_addr_i == ADDR_MODE) mode_q <= cfg_wdata_i;
      else if (cfg_addr_i == ADDR_AUX) aux_q <= cfg_wdata_i[SEL_W-1:0];
    end else if (mem_wr) begin
      for (int b = 0; b < MEM_DW; b++)
        tab_q[{mem_waddr_i[MEM_AW-1], b[QB-1:0], mem_waddr_i[LUT_K-1:0]}] <= mem_wdata_i[b];
    end
  end

  assign tab_o  = tab_q;
  assign mode_o = mode_q;
  assign aux_o  = aux_q;

  // R2
  mode_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == ADDR_MODE) |=> (mode_q == $past(cfg_wdata_i)));

  // R7
  rom_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_we_i && is_mem && is_rom) |=> $stable(tab_q));

  // R6
  mem_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr |=> (mem_word(tab_q, $past(mem_waddr_i)) == $past(mem_wdata_i)));
endmodule

// File: rtl/tq_quad_logic.sv
module tq_quad_logic
  import tq_cell_pkg::*;
(
  input  logic [QUAD_W*LUT_BITS-1:0] tab_i,
  input  logic [QUAD_W*LUT_K-1:0]    sel_i,
  input  logic                       cin_i,
  output logic [QUAD_W-1:0]          lut_o,
  output logic [QUAD_W-1:0]          sum_o,
  output logic                       cout_o
);
  for (genvar j = 0; j < QUAD_W; j++) begin : g_bit
    logic [LUT_BITS-1:0] tt;
    logic                c_in;
    logic                c_out;
    assign tt       = tab_i[j*LUT_BITS +: LUT_BITS];
    assign lut_o[j] = tt[sel_i[j*LUT_K +: LUT_K]];
    if (j == 0) begin : g_first
      assign c_in = cin_i;
    end else begin : g_next
      assign c_in = g_bit[j-1].c_out;
    end
    // table output acts as propagate; otherwise carry is the first select input
    assign c_out    = lut_o[j] ? c_in : sel_i[j*LUT_K];
    assign sum_o[j] = lut_o[j] ^ c_in;
  end
  assign cout_o = g_bit[QUAD_W-1].c_out;
endmodule

// File: rtl/tq_store_quad.sv
module tq_store_quad
  import tq_cell_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  grp_cfg_t          cfg_i,
  input  logic              cfg_quiet_i,
  input  logic              ce_i,
  input  logic              sr_i,
  input  logic [QUAD_W-1:0] lut_i,
  input  logic [QUAD_W-1:0] pin_i,
  output logic [QUAD_W-1:0] q_o
);
  logic              clk_int;
  logic [QUAD_W-1:0] din;
  logic [QUAD_W-1:0] ff_q;
  logic [QUAD_W-1:0] lat_q;

  assign clk_int = clk_i ^ cfg_i.fall;

  always_comb begin
    case (cfg_i.src)
      SRC_LUT: din = lut_i;
      SRC_PIN: din = pin_i ^ {QUAD_W{cfg_i.inv}};
      SRC_ONE: din = '1;
      default: din = '0;
    endcase
  end

  always_ff @(posedge clk_int or negedge rst_ni) begin
    if (!rst_ni)   ff_q <= '0;
    else if (sr_i) ff_q <= {QUAD_W{cfg_i.srval}};
    else if (ce_i) ff_q <= din;
  end

  always_latch begin
    if (!rst_ni) lat_q <= '0;
    else if (clk_int && (sr_i || ce_i)) lat_q <= sr_i ? {QUAD_W{cfg_i.srval}} : din;
  end

  assign q_o = cfg_i.latch ? lat_q : ff_q;

  // R9
  sr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_i && cfg_quiet_i && !cfg_i.fall && !cfg_i.latch) |=> (q_o == {QUAD_W{$past(cfg_i.srval)}}));

  // R9
  ce_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sr_i && !ce_i && cfg_quiet_i && !cfg_i.fall && !cfg_i.latch) |=> $stable(q_o));
endmodule

// File: rtl/tq_cell.sv
module tq_cell
  import tq_cell_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [CFG_AW-1:0]       cfg_addr_i,
  input  logic [CFG_W-1:0]        cfg_wdata_i,
  input  logic [NUM_LUT*LUT_K-1:0] lut_in_i,
  input  logic [NUM_QUAD-1:0]     cin_i,
  input  logic [NUM_LUT-1:0]      d_i,
  input  logic [NUM_QUAD-1:0]     ce_i,
  input  logic [NUM_QUAD-1:0]     sr_i,
  input  logic                    d9_i,
  input  logic                    ce9_i,
  input  logic                    mem_we_i,
  input  logic [MEM_AW-1:0]       mem_waddr_i,
  input  logic [MEM_AW-1:0]       mem_raddr_i,
  input  logic [MEM_DW-1:0]       mem_wdata_i,
  output logic [NUM_LUT-1:0]      comb_o,
  output logic [NUM_QUAD-1:0]     cout_o,
  output logic [NUM_LUT-1:0]      q_o,
  output logic                    r9_o
);
  localparam int unsigned QT_W = QUAD_W * LUT_BITS;
  localparam int unsigned QS_W = QUAD_W * LUT_K;

  logic [TAB_W-1:0]    tab;
  logic [CFG_W-1:0]    mode;
  logic [SEL_W-1:0]    aux;
  op_e                 op;
  mem_e                kind;
  logic [NUM_LUT-1:0]  lut_all;
  logic [NUM_LUT-1:0]  sum_all;
  logic [NUM_QUAD-1:0] cin_q;
  logic [NUM_QUAD-1:0] cout_q;
  logic [MEM_AW-1:0]   rd_addr;
  logic [MEM_DW-1:0]   rd_data;
  logic                arith;
  logic                r9_d;
  logic                r9_q;

  tq_cfg_store u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .mem_we_i    (mem_we_i),
    .mem_waddr_i (mem_waddr_i),
    .mem_wdata_i (mem_wdata_i),
    .tab_o       (tab),
    .mode_o      (mode),
    .aux_o       (aux)
  );

  assign op    = op_e'(mode[1:0]);
  assign kind  = mem_e'(mode[3:2]);
  assign arith = (op == OP_ADD4) || (op == OP_ADD8);

  for (genvar g = 0; g < NUM_QUAD; g++) begin : g_quad
    if (g == 0) begin : g_head
      assign cin_q[g] = cin_i[g];
    end else begin : g_tail
      assign cin_q[g] = (op == OP_ADD8) ? cout_q[g-1] : cin_i[g];
    end

    tq_quad_logic u_logic (
      .tab_i  (tab[g*QT_W +: QT_W]),
      .sel_i  (lut_in_i[g*QS_W +: QS_W]),
      .cin_i  (cin_q[g]),
      .lut_o  (lut_all[g*QUAD_W +: QUAD_W]),
      .sum_o  (sum_all[g*QUAD_W +: QUAD_W]),
      .cout_o (cout_q[g])
    );

    tq_store_quad u_store (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cfg_i       (grp_cfg(mode, g)),
      .cfg_quiet_i (!cfg_we_i),
      .ce_i        (ce_i[g]),
      .sr_i        (sr_i[g]),
      .lut_i       (comb_o[g*QUAD_W +: QUAD_W]),
      .pin_i       (d_i[g*QUAD_W +: QUAD_W]),
      .q_o         (q_o[g*QUAD_W +: QUAD_W])
    );
  end

  assign rd_addr = (kind == MEM_DP) ? mem_raddr_i : mem_waddr_i;
  assign rd_data = mem_word(tab, rd_addr);

  always_comb begin
    case (op)
      OP_LOGIC: comb_o = lut_all;
      OP_MEM:   comb_o = {{(NUM_LUT-MEM_DW){1'b0}}, rd_data};
      default:  comb_o = sum_all;
    endcase
  end

  assign cout_o = arith ? cout_q : '0;

  always_comb begin
    case (aux)
      2'd0:    r9_d = cout_o[0];
      2'd1:    r9_d = cout_o[NUM_QUAD-1];
      2'd2:    r9_d = d9_i;
      default: r9_d = ~d9_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    r9_q <= 1'b0;
    else if (ce9_i) r9_q <= r9_d;
  end
  assign r9_o = r9_q;

  // R4
  prop4_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_ADD4 && (&lut_all[QUAD_W-1:0])) |-> (cout_o[0] == cin_i[0]));

  // R5
  chain8_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_ADD8 && (&lut_all)) |-> (cout_o[NUM_QUAD-1] == cin_i[0]));

  // R12
  r9_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce9_i |=> $stable(r9_o));
endmodule

// File: tb/sim_tq_cell.sv
module sim_tq_cell;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic [31:0] lut_in_i = '0;
  logic [1:0]  cin_i = '0;
  logic [7:0]  d_i = '0;
  logic [1:0]  ce_i = '0;
  logic [1:0]  sr_i = '0;
  logic        d9_i = 1'b0;
  logic        ce9_i = 1'b0;
  logic        mem_we_i = 1'b0;
  logic [4:0]  mem_waddr_i = '0;
  logic [4:0]  mem_raddr_i = '0;
  logic [3:0]  mem_wdata_i = '0;
  logic [7:0]  comb_o;
  logic [1:0]  cout_o;
  logic [7:0]  q_o;
  logic        r9_o;

  int checks = 0;
  int errs = 0;

  logic [15:0] m_tab [8];
  logic [15:0] m_mode = '0;
  logic [1:0]  m_aux = '0;
  logic [7:0]  m_q = '0;
  logic        m_r9 = 1'b0;

  always #5 clk_i = ~clk_i;

  tq_cell u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .lut_in_i(lut_in_i), .cin_i(cin_i), .d_i(d_i),
    .ce_i(ce_i), .sr_i(sr_i), .d9_i(d9_i), .ce9_i(ce9_i), .mem_we_i(mem_we_i),
    .mem_waddr_i(mem_waddr_i), .mem_raddr_i(mem_raddr_i), .mem_wdata_i(mem_wdata_i),
    .comb_o(comb_o), .cout_o(cout_o), .q_o(q_o), .r9_o(r9_o)
  );

  function automatic void calc(output logic [7:0] c, output logic [1:0] co);
    logic [7:0] lo;
    logic       carry;
    logic [4:0] ra;
    for (int k = 0; k < 8; k++) lo[k] = m_tab[k][lut_in_i[4*k +: 4]];
    c = '0;
    co = '0;
    case (m_mode[1:0])
      2'd0: c = lo;
      2'd3: begin
        ra = (m_mode[3:2] == 2'd1) ? mem_raddr_i : mem_waddr_i;
        for (int b = 0; b < 4; b++) c[b] = m_tab[ra[4]*4 + b][ra[3:0]];
      end
      default: begin
        for (int q = 0; q < 2; q++) begin
          carry = (q == 1 && m_mode[1:0] == 2'd2) ? co[0] : cin_i[q];
          for (int j = 0; j < 4; j++) begin
            c[4*q+j] = lo[4*q+j] ^ carry;
            carry = lo[4*q+j] ? carry : lut_in_i[4*(4*q+j)];
          end
          co[q] = carry;
        end
      end
    endcase
  endfunction

  function automatic logic elem_next(int e, logic [7:0] c);
    int g;
    logic din;
    g = e / 4;
    case (m_mode[4+2*g +: 2])
      2'd0: din = c[e];
      2'd1: din = d_i[e] ^ m_mode[8+g];
      2'd2: din = 1'b1;
      default: din = 1'b0;
    endcase
    if (sr_i[g]) return m_mode[14+g];
    if (ce_i[g]) return din;
    return m_q[e];
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(string req);
    logic [7:0] c;
    logic [1:0] co;
    logic [7:0] nq;
    @(negedge clk_i);
    calc(c, co);
    nq = m_q;
    for (int e = 0; e < 8; e++)
      if (m_mode[10+e/4] || m_mode[12+e/4]) nq[e] = elem_next(e, c);
    m_q = nq;
    #1;
    calc(c, co);
    check(req, "comb_o", 32'(comb_o), 32'(c));
    check(req, "cout_o", 32'(cout_o), 32'(co));
    check(req, "q_o", 32'(q_o), 32'(m_q));
    check(req, "r9_o", 32'(r9_o), 32'(m_r9));
    @(posedge clk_i);
    calc(c, co);
    nq = m_q;
    for (int e = 0; e < 8; e++)
      if (!m_mode[10+e/4] && !m_mode[12+e/4]) nq[e] = elem_next(e, c);
    if (ce9_i) begin
      case (m_aux)
        2'd0: m_r9 = co[0];
        2'd1: m_r9 = co[1];
        2'd2: m_r9 = d9_i;
        default: m_r9 = ~d9_i;
      endcase
    end
    m_q = nq;
    if (cfg_we_i) begin
      if (cfg_addr_i < 4'd8) m_tab[cfg_addr_i[2:0]] = cfg_wdata_i;
      else if (cfg_addr_i == 4'd8) m_mode = cfg_wdata_i;
      else if (cfg_addr_i == 4'd9) m_aux = cfg_wdata_i[1:0];
    end else if (mem_we_i && m_mode[1:0] == 2'd3 && !m_mode[3]) begin
      for (int b = 0; b < 4; b++) m_tab[mem_waddr_i[4]*4 + b][mem_waddr_i[3:0]] = mem_wdata_i[b];
    end
    #1;
  endtask

  task automatic rnd();
    lut_in_i    = $urandom;
    cin_i       = 2'($urandom);
    d_i         = 8'($urandom);
    ce_i        = 2'($urandom);
    sr_i        = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
    d9_i        = 1'($urandom);
    ce9_i       = 1'($urandom);
    mem_we_i    = 1'($urandom);
    mem_waddr_i = 5'($urandom);
    mem_raddr_i = 5'($urandom);
    mem_wdata_i = 4'($urandom);
  endtask

  task automatic run(int n, string req);
    repeat (n) begin
      rnd();
      step(req);
    end
  endtask

  task automatic wr_cfg(logic [3:0] a, logic [15:0] w, string req);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = w;
    ce_i = '0; sr_i = '0; mem_we_i = 1'b0;
    step(req);
    cfg_we_i = 1'b0;
  endtask

  // force flop and latch copies to the same value before a mode change
  task automatic set_mode(logic [15:0] w, string req);
    ce_i = '0; sr_i = 2'b11; mem_we_i = 1'b0;
    step(req);
    wr_cfg(4'd8, w, req);
  endtask

  initial begin : wd
    #2_000_000;
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    logic [15:0] pat [8];
    pat = '{16'h6666, 16'h8000, 16'hFFFE, 16'h6996, 16'hAAAA, 16'h00FF, 16'hCAFE, 16'h1234};
    for (int k = 0; k < 8; k++) m_tab[k] = '0;
    lut_in_i = 32'h9C3F_0A51;
    #23;
    check("R1", "q_o in reset", 32'(q_o), 0);
    check("R1", "comb_o in reset", 32'(comb_o), 0);
    check("R1", "r9_o in reset", 32'(r9_o), 0);
    #4 rst_ni = 1'b1;
    step("R1");
    step("R1");

    for (int k = 0; k < 8; k++) wr_cfg(4'(k), pat[k], "R2");
    wr_cfg(4'd12, 16'hFFFF, "R2");
    run(30, "R3");

    for (int k = 0; k < 8; k++) wr_cfg(4'(k), 16'h6666, "R4");
    set_mode(16'h0001, "R4");
    lut_in_i = 32'h1111_1111; cin_i = 2'b01; ce_i = 2'b11; sr_i = '0;
    step("R4");
    run(30, "R4");
    set_mode(16'h0002, "R5");
    lut_in_i = 32'h1111_1111; cin_i = 2'b01; step("R5");
    lut_in_i = 32'h1111_1111; cin_i = 2'b10; step("R5");
    run(30, "R5");
    wr_cfg(4'd9, 16'h0001, "R12");
    run(20, "R12");

    set_mode(16'h0003, "R6");
    run(40, "R6");
    set_mode(16'h0007, "R6");
    run(40, "R6");
    set_mode(16'h000B, "R7");
    run(30, "R7");
    set_mode(16'h0000, "R7");
    run(20, "R7");
    set_mode(16'h0003, "R7");
    run(10, "R7");

    set_mode(16'h0190, "R8");
    run(20, "R8");
    set_mode(16'h0070, "R8");
    run(20, "R8");
    set_mode(16'h4040, "R9");
    run(40, "R9");
    set_mode(16'h4840, "R10");
    run(30, "R10");
    set_mode(16'h4C50, "R10");
    run(30, "R10");
    set_mode(16'h7840, "R11");
    run(30, "R11");
    set_mode(16'h3040, "R11");
    run(30, "R11");

    wr_cfg(4'd9, 16'h0002, "R12");
    run(20, "R12");
    wr_cfg(4'd9, 16'h0003, "R12");
    run(20, "R12");
    set_mode(16'h0002, "R12");
    wr_cfg(4'd9, 16'h0000, "R12");
    run(20, "R12");

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule